// File: doc/BRIEF.md
# Rotation BIST Pattern Generator

This block is an on-chip source of deterministic test stimulus. Every stimulus bit of a circuit under test, whether a primary input or a scan cell, is held in one circular register that is `WIDTH` bits long. A run walks through a list of seeds. For each seed the register is loaded in one cycle. The loaded value is either the fixed reset value or a value built bit by bit from live response bits of the circuit. The register then rotates left by one position per clock, for as many clocks as that seed asks for. A new pattern therefore appears on every clock, and no seed values are stored.

For each seed and each register bit, the programming side picks a logic operation and two response-bit indices. For each seed it also picks a rotation count and whether the seed comes from the reset value. Software writes this configuration while the block is idle. It then sets the index of the last seed and pulses start. The block raises done for one cycle once the final pattern has been applied.

Top module: `rot_bist_gen`

## Requirements
- R1: While reset is active and right after it, the pattern output equals parameter `RESET_VAL`, and both pattern-valid and done are low.
- R2: When start is sampled high in idle, the block spends one load cycle with pattern-valid low. The first seed is presented with pattern-valid high in the cycle after that.
- R3: In each valid cycle that follows another valid cycle, the pattern is the previous one rotated left by one bit, with the most significant bit moving into bit 0.
- R4: A seed whose rotation count is r produces exactly r+1 valid cycles: the seed itself and then r rotations. r ranges from 0 to `WIDTH`-1.
- R5: The 4-bit per-bit operation code produces the seed bit from response bits A and B as follows: 0 gives A, 1 gives NOT A, 2 gives 1, 3 gives 0, 4 gives A AND B, 5 gives A OR B, 6 gives NAND, 7 gives NOR, 8 gives XOR and 9 gives XNOR. Codes 10 to 15 give 0.
- R6: The A and B indices choose which bits of the response input feed each register bit. The response input is sampled only at the clock edge that ends the load cycle, so later changes to it do not affect the applied patterns.
- R7: A seed whose reset flag is set loads `RESET_VAL` whatever the responses are.
- R8: Seeds are applied in index order, from 0 up to the last-seed index sampled at start. Between two seeds there are exactly two cycles with pattern-valid low. During those two cycles the pattern output holds its last value.
- R9: Done is high for exactly one cycle, and that cycle directly follows the last valid pattern of the last seed. Pattern-valid is low while done is high. The block then returns to idle and accepts a new start.
- R10: The configuration persists across runs. A bit write stores the operation and the A and B indices for the given (seed, bit) pair. A seed write stores the rotation count and the reset flag for the given seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when sampled high in idle |
| last_seed_i | input | SEED_W | Index of the last seed of the run, sampled at start |
| cfg_bit_we_i | input | 1 | Writes the per-bit operation and indices |
| cfg_seed_we_i | input | 1 | Writes the per-seed rotation count and reset flag |
| cfg_seed_i | input | SEED_W | Seed addressed by a write |
| cfg_bit_i | input | BIT_W | Register bit addressed by a bit write |
| cfg_op_i | input | 4 | Operation code (R5) |
| cfg_sel_a_i | input | SEL_W | Response index for operand A |
| cfg_sel_b_i | input | SEL_W | Response index for operand B |
| cfg_rot_i | input | CNT_W | Rotation count of the seed |
| cfg_use_rst_i | input | 1 | Seed loads `RESET_VAL` when set |
| resp_i | input | RESP_W | Response bits from internal nets |
| pattern_o | output | WIDTH | Current stimulus pattern |
| pattern_valid_o | output | 1 | High while pattern_o is a pattern to apply |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
A corrupted shift register shows up at once. The next valid cycle is not a one-bit left rotation of the current one, or the whole sequence that follows drifts from the seed predicted from the programmed operations and the sampled responses. A wrong rotation counter or seed index shows a little later: a seed's run has the wrong length, a seed's value is wrong, or done comes too early or too late, all within that seed's window. The bench therefore tracks every cycle of every run against a sequence it builds from the configuration it wrote and the responses it drove.

// File: rtl/rot_bist_gen.sv
module rot_bist_gen #(
  parameter int WIDTH = 8,
  parameter int RESP_W = 8,
  parameter int SEEDS = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  localparam int CNT_W = $clog2(WIDTH),
  localparam int BIT_W = $clog2(WIDTH),
  localparam int SEL_W = $clog2(RESP_W),
  localparam int SEED_W = $clog2(SEEDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEED_W-1:0] last_seed_i,
  input  logic              cfg_bit_we_i,
  input  logic              cfg_seed_we_i,
  input  logic [SEED_W-1:0] cfg_seed_i,
  input  logic [BIT_W-1:0]  cfg_bit_i,
  input  logic [3:0]        cfg_op_i,
  input  logic [SEL_W-1:0]  cfg_sel_a_i,
  input  logic [SEL_W-1:0]  cfg_sel_b_i,
  input  logic [CNT_W-1:0]  cfg_rot_i,
  input  logic              cfg_use_rst_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [WIDTH-1:0]  pattern_o,
  output logic              pattern_valid_o,
  output logic              done_o
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ROT, S_NEXT, S_DONE} st_t;

  st_t               st_q;
  logic [WIDTH-1:0]  csr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEED_W-1:0] seed_q;
  logic [SEED_W-1:0] last_q;
  logic [WIDTH-1:0]  fb_seed;

  logic [3:0]       op_q  [SEEDS][WIDTH];
  logic [SEL_W-1:0] sa_q  [SEEDS][WIDTH];
  logic [SEL_W-1:0] sb_q  [SEEDS][WIDTH];
  logic [CNT_W-1:0] rot_q [SEEDS];
  logic [SEEDS-1:0] use_rst_q;

  function automatic logic fb_bit(input logic [3:0] op, input logic a, input logic b);
    case (op)
      4'd0:    return a;
      4'd1:    return ~a;
      4'd2:    return 1'b1;
      4'd3:    return 1'b0;
      4'd4:    return a & b;
      4'd5:    return a | b;
      4'd6:    return ~(a & b);
      4'd7:    return ~(a | b);
      4'd8:    return a ^ b;
      4'd9:    return ~(a ^ b);
      default: return 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < WIDTH; g++) begin : g_fb
    assign fb_seed[g] = fb_bit(op_q[seed_q][g],
                               resp_i[sa_q[seed_q][g]],
                               resp_i[sb_q[seed_q][g]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SEEDS; s++) begin
        rot_q[s] <= '0;
        for (int i = 0; i < WIDTH; i++) begin
          op_q[s][i] <= '0;
          sa_q[s][i] <= '0;
          sb_q[s][i] <= '0;
        end
      end
      use_rst_q <= '0;
    end else begin
      if (cfg_bit_we_i && int'(cfg_bit_i) < WIDTH) begin
        op_q[cfg_seed_i][cfg_bit_i] <= cfg_op_i;
        sa_q[cfg_seed_i][cfg_bit_i] <= cfg_sel_a_i;
        sb_q[cfg_seed_i][cfg_bit_i] <= cfg_sel_b_i;
      end
      if (cfg_seed_we_i) begin
        rot_q[cfg_seed_i]     <= cfg_rot_i;
        use_rst_q[cfg_seed_i] <= cfg_use_rst_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      csr_q  <= RESET_VAL;
      cnt_q  <= '0;
      seed_q <= '0;
      last_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          seed_q <= '0;
          last_q <= last_seed_i;
          st_q   <= S_LOAD;
        end
        S_LOAD: begin
          csr_q <= use_rst_q[seed_q] ? RESET_VAL : fb_seed;
          cnt_q <= rot_q[seed_q];
          st_q  <= S_ROT;
        end
        S_ROT: begin
          if (cnt_q == '0) begin
            st_q <= (seed_q == last_q) ? S_DONE : S_NEXT;
          end else begin
            csr_q <= {csr_q[WIDTH-2:0], csr_q[WIDTH-1]};
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_NEXT: begin
          seed_q <= seed_q + 1'b1;
          st_q   <= S_LOAD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign pattern_o       = csr_q;
  assign pattern_valid_o = (st_q == S_ROT);
  assign done_o          = (st_q == S_DONE);

endmodule

// File: rtl/rot_bist_gen_chk.sv
module rot_bist_gen_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pattern_o,
  input logic             pattern_valid_o,
  input logic             done_o
);

  function automatic logic [WIDTH-1:0] rotl(input logic [WIDTH-1:0] v);
    return {v[WIDTH-2:0], v[WIDTH-1]};
  endfunction

  p_rotate_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_valid_o && $past(pattern_valid_o) |-> pattern_o == rotl($past(pattern_o)));

  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pattern_valid_o |-> $stable(pattern_o));

  p_gap_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pattern_valid_o) |-> !$past(pattern_valid_o, 2));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pattern_valid_o) && !pattern_valid_o);

endmodule

bind rot_bist_gen rot_bist_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pattern_o(pattern_o),
  .pattern_valid_o(pattern_valid_o),
  .done_o(done_o)
);

// File: tb/rot_bist_gen_bench.sv
module rot_bist_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int R = 8;
  localparam int S = 4;
  localparam logic [W-1:0] RV = 8'hB4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] last_seed_i = '0;
  logic cfg_bit_we_i = 1'b0, cfg_seed_we_i = 1'b0;
  logic [1:0] cfg_seed_i = '0;
  logic [2:0] cfg_bit_i = '0;
  logic [3:0] cfg_op_i = '0;
  logic [2:0] cfg_sel_a_i = '0, cfg_sel_b_i = '0;
  logic [2:0] cfg_rot_i = '0;
  logic cfg_use_rst_i = 1'b0;
  logic [R-1:0] resp_i = '0;
  logic [W-1:0] pattern_o;
  logic pattern_valid_o, done_o;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] b_op [S][W];
  logic [2:0] b_sa [S][W];
  logic [2:0] b_sb [S][W];
  int         b_rot [S];
  logic       b_rst [S];
  logic [R-1:0] resp_seq [S];

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_bist_gen #(.WIDTH(W), .RESP_W(R), .SEEDS(S), .RESET_VAL(RV)) u_rot_bist_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_seed_i(last_seed_i),
    .cfg_bit_we_i(cfg_bit_we_i), .cfg_seed_we_i(cfg_seed_we_i),
    .cfg_seed_i(cfg_seed_i), .cfg_bit_i(cfg_bit_i), .cfg_op_i(cfg_op_i),
    .cfg_sel_a_i(cfg_sel_a_i), .cfg_sel_b_i(cfg_sel_b_i), .cfg_rot_i(cfg_rot_i),
    .cfg_use_rst_i(cfg_use_rst_i), .resp_i(resp_i),
    .pattern_o(pattern_o), .pattern_valid_o(pattern_valid_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_op(input logic [3:0] op, input logic a, input logic b);
    case (op)
      4'd0: return a;        4'd1: return !a;
      4'd2: return 1'b1;     4'd3: return 1'b0;
      4'd4: return a && b;   4'd5: return a || b;
      4'd6: return !(a && b); 4'd7: return !(a || b);
      4'd8: return a != b;   4'd9: return a == b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_seed(input int k);
    logic [W-1:0] v;
    if (b_rst[k]) return RV;
    for (int i = 0; i < W; i++)
      v[i] = ref_op(b_op[k][i], resp_seq[k][b_sa[k][i]], resp_seq[k][b_sb[k][i]]);
    return v;
  endfunction

  function automatic logic [W-1:0] rl(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  task automatic wr_bit(input int s, input int i, input int op, input int a, input int b);
    @(negedge clk);
    cfg_bit_we_i = 1'b1; cfg_seed_i = 2'(s); cfg_bit_i = 3'(i);
    cfg_op_i = 4'(op); cfg_sel_a_i = 3'(a); cfg_sel_b_i = 3'(b);
    b_op[s][i] = 4'(op); b_sa[s][i] = 3'(a); b_sb[s][i] = 3'(b);
    @(negedge clk);
    cfg_bit_we_i = 1'b0;
  endtask

  task automatic wr_seed(input int s, input int rot, input logic ur);
    @(negedge clk);
    cfg_seed_we_i = 1'b1; cfg_seed_i = 2'(s); cfg_rot_i = 3'(rot); cfg_use_rst_i = ur;
    b_rot[s] = rot; b_rst[s] = ur;
    @(negedge clk);
    cfg_seed_we_i = 1'b0;
  endtask

  task automatic run(input int last);
    logic [W-1:0] exp, prev;
    @(negedge clk);
    last_seed_i = 2'(last);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    last_seed_i = 2'(~last);
    prev = pattern_o;
    for (int k = 0; k <= last; k++) begin
      chk("R2/R8 load cycle not valid", 32'(pattern_valid_o), 32'd0);
      chk("R8 pattern held in gap", 32'(pattern_o), 32'(prev));
      resp_i = resp_seq[k];
      exp = exp_seed(k);
      @(negedge clk);
      resp_i = ~resp_seq[k];
      for (int j = 0; j <= b_rot[k]; j++) begin
        chk("R4 valid during rotation", 32'(pattern_valid_o), 32'd1);
        chk("R3/R5/R6/R7 pattern", 32'(pattern_o), 32'(exp));
        chk("R9 no early done", 32'(done_o), 32'd0);
        prev = exp;
        exp = rl(exp);
        @(negedge clk);
      end
      if (k != last) begin
        chk("R4/R8 advance cycle not valid", 32'(pattern_valid_o), 32'd0);
        chk("R8 pattern held in gap", 32'(pattern_o), 32'(prev));
        @(negedge clk);
      end
    end
    chk("R9 done after last pattern", 32'(done_o), 32'd1);
    chk("R9 not valid with done", 32'(pattern_valid_o), 32'd0);
    @(negedge clk);
    chk("R9 done lasts one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int s = 0; s < S; s++) begin
      b_rot[s] = 0; b_rst[s] = 1'b0; resp_seq[s] = '0;
      for (int i = 0; i < W; i++) begin b_op[s][i] = '0; b_sa[s][i] = '0; b_sb[s][i] = '0; end
    end
    #(CLK_PERIOD * 3);
    chk("R1 reset pattern", 32'(pattern_o), 32'(RV));
    chk("R1 reset valid", 32'(pattern_valid_o), 32'd0);
    chk("R1 reset done", 32'(done_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pattern after reset", 32'(pattern_o), 32'(RV));

    // R5 R6: every op code with varying selects and responses
    wr_seed(0, 0, 1'b0);
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < W; i++) wr_bit(0, i, op, (i + op) % R, (3 * i + op + 1) % R);
      foreach (resp_seq[q]) if (q == 0) begin
        resp_seq[0] = 8'h00; run(0);
        resp_seq[0] = 8'hFF; run(0);
        resp_seq[0] = 8'h5A; run(0);
        resp_seq[0] = 8'hC3; run(0);
        resp_seq[0] = 8'h96; run(0);
      end
    end

    // R4: every rotation count on a pass-through seed
    for (int i = 0; i < W; i++) wr_bit(0, i, 0, i, 0);
    resp_seq[0] = 8'h81;
    for (int r = 0; r < W; r++) begin
      wr_seed(0, r, 1'b0);
      run(0);
    end

    // R7: reset-value seed ignores responses
    wr_seed(0, W - 1, 1'b1);
    resp_seq[0] = 8'h3C;
    run(0);

    // R8 R10: four seeds, mixed ops, reset and feedback seeds
    for (int s = 0; s < S; s++)
      for (int i = 0; i < W; i++) wr_bit(s, i, (i + s) % 10, (i + 2 * s) % R, (5 * i + s) % R);
    wr_seed(0, 2, 1'b0); wr_seed(1, 0, 1'b0); wr_seed(2, 7, 1'b1); wr_seed(3, 3, 1'b0);
    resp_seq[0] = 8'hA7; resp_seq[1] = 8'h19; resp_seq[2] = 8'hE2; resp_seq[3] = 8'h6D;
    run(3);
    resp_seq[0] = 8'h42; resp_seq[1] = 8'hBD;
    run(1);
    run(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule